// File: doc/BRIEF.md
# Addressed Keyboard Input Device

This block stands in for a keyboard on a shared interrupt bus. Every fixed number of clock cycles it reports a new key press by raising its interrupt request, and it then holds the code of that key until the next press. The keys it produces come from a built-in twelve-character message. When the message is used up, it starts again from the first character.

The device answers two kinds of bus cycle on the shared 32-bit data lines. In an interrupt acknowledge cycle it returns its device ID so that the processor can index its handler table. In an addressed read, the processor's device address register holds the device address, and the device returns the current character as a zero-extended 32-bit word. The device is the second link of a priority daisy chain. Its acknowledge input comes from the forwarded acknowledge of the device upstream. It passes on any acknowledge it does not consume.

Top module: `keypad_port`

## Requirements
- R1: After reset the interrupt request is low, the data lines are not driven (drive-enable 0, data 0x00000000), and no key press is pending.
- R2: The interrupt request rises at the 2500th rising clock edge after reset is released. It rises again every 2500 edges after that, whatever the acknowledge timing.
- R3: When the acknowledge input is high while the interrupt request is high, the request is low after the next edge. In the following cycle the device drives its ID 0x00000002 with drive-enable high for exactly one cycle. That acknowledge is not forwarded. A pending request stays high until it is acknowledged.
- R4: When the acknowledge input is high while no request is pending and no ID response is active, the acknowledge output follows it in the same cycle, and the device does not drive the data lines.
- R5: When the address input equals 0x00000002, the device drives the current key in the same cycle as {25 zero bits, 7-bit ASCII code}. Any other address, 0x00000000 included, leaves the lines undriven. An undriven data output reads 0.
- R6: The first interrupt makes 'H' (0x48) the current key. Each later interrupt advances one character through "Hello world!". After '!' (0x21) the next interrupt wraps back to 'H'.
- R7: The current key does not change between interrupts, so repeated reads return the same value.
- R8: If an ID response and a matching address read fall in the same cycle, the ID is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | output | 1 | Interrupt request onto the shared line |
| ack_in | input | 1 | Acknowledge from the upstream device |
| ack_out | output | 1 | Acknowledge forwarded downstream |
| dev_addr | input | 32 | Device address register value |
| bus_data | output | 32 | Value for the shared data lines |
| bus_drive | output | 1 | Drive-enable for bus_data |

## Verification
The hardest cases to reach are the wrap of the message after the twelfth interrupt and an ID response that overlaps an addressed read. The stimulus serves thirteen consecutive interrupts at the default period, and each interrupt is checked against an expected-character table. During the first acknowledge the address stays at the device address, so the read and the ID response meet in one cycle.

// File: rtl/keypad_port.sv
module keypad_port #(
  parameter int DEV_ID = 2,
  parameter int TICKS  = 2500
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        irq,
  input  logic        ack_in,
  output logic        ack_out,
  input  logic [31:0] dev_addr,
  output logic [31:0] bus_data,
  output logic        bus_drive
);
  localparam int MSG_LEN = 12;
  localparam int IW = $clog2(MSG_LEN);
  localparam int CW = $clog2(TICKS);
  localparam logic [IW-1:0] LAST = IW'(MSG_LEN - 1);

  function automatic logic [6:0] glyph(input logic [IW-1:0] i);
    case (i)
      4'd0:    glyph = 7'h48;
      4'd1:    glyph = 7'h65;
      4'd2:    glyph = 7'h6C;
      4'd3:    glyph = 7'h6C;
      4'd4:    glyph = 7'h6F;
      4'd5:    glyph = 7'h20;
      4'd6:    glyph = 7'h77;
      4'd7:    glyph = 7'h6F;
      4'd8:    glyph = 7'h72;
      4'd9:    glyph = 7'h6C;
      4'd10:   glyph = 7'h64;
      default: glyph = 7'h21;
    endcase
  endfunction

  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          resp;
  logic          tick, take, sel;

  assign tick = (cnt == CW'(TICKS - 1));
  assign take = ack_in & irq;
  assign sel  = (dev_addr == 32'(DEV_ID)) && (dev_addr != 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      idx  <= LAST;
      irq  <= 1'b0;
      resp <= 1'b0;
    end else begin
      cnt  <= tick ? '0 : cnt + 1'b1;
      resp <= take;
      irq  <= tick | (irq & ~ack_in);
      if (tick) idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  assign ack_out   = ack_in & ~irq & ~resp;
  assign bus_drive = resp | sel;
  assign bus_data  = resp ? 32'(DEV_ID) :
                     sel  ? {25'd0, glyph(idx)} : 32'd0;
endmodule

// File: rtl/keypad_port_chk.sv
module keypad_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        ack_in,
  input logic        ack_out,
  input logic [31:0] dev_addr,
  input logic [31:0] bus_data,
  input logic        bus_drive
);
  // R3
  ack_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && irq) |=> (bus_drive && bus_data == 32'd2 && !ack_out));
  // R3
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ack_in));
  // R4
  fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> (ack_in && !irq));
  // R5
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (bus_data == 32'd0));
  // R5
  width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && bus_data != 32'd2) |-> (bus_data[31:7] == 25'd0));
  // R5
  nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_addr == 32'd0 && !$past(ack_in && irq)) |-> !bus_drive);
endmodule

bind keypad_port keypad_port_chk u_chk (.*);

// File: tb/keypad_port_tb.sv
module keypad_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq, ack_in = 1'b0, ack_out, bus_drive;
  logic [31:0] dev_addr = 32'd0, bus_data;

  int checks = 0, errors = 0, cyc = 0, last_rise = 0;
  bit done = 1'b0;

  localparam logic [6:0] EXP [13] = '{7'h48, 7'h65, 7'h6C, 7'h6C, 7'h6F, 7'h20,
                                      7'h77, 7'h6F, 7'h72, 7'h6C, 7'h64, 7'h21, 7'h48};

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  keypad_port u_dut (.clk(clk), .rst_n(rst_n), .irq(irq), .ack_in(ack_in), .ack_out(ack_out),
                     .dev_addr(dev_addr), .bus_data(bus_data), .bus_drive(bus_drive));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 drive", {31'd0, bus_drive}, 32'd0);
    chk("R1 data", bus_data, 32'd0);
    ack_in = 1'b1; #1;
    chk("R4 fwd", {31'd0, ack_out}, 32'd1);
    chk("R4 nodrive", {31'd0, bus_drive}, 32'd0);
    ack_in = 1'b0;
    dev_addr = 32'd3; #1;
    chk("R5 other addr", {31'd0, bus_drive}, 32'd0);
    dev_addr = 32'd0;

    for (int k = 0; k < 13; k++) begin
      while (irq !== 1'b1) @(negedge clk);
      if (k == 0) chk("R2 first", cyc, 32'd2500);
      else chk("R2 period", cyc - last_rise, 32'd2500);
      last_rise = cyc;
      @(negedge clk);
      chk("R3 held", {31'd0, irq}, 32'd1);
      dev_addr = 32'd2; #1;
      chk("R6 char", bus_data, {25'd0, EXP[k]});
      chk("R5 drive", {31'd0, bus_drive}, 32'd1);
      @(negedge clk);
      chk("R7 stable", bus_data, {25'd0, EXP[k]});
      if (k != 0) dev_addr = 32'd0;
      #1;
      if (k != 0) chk("R5 addr0", {31'd0, bus_drive}, 32'd0);
      ack_in = 1'b1; #1;
      chk("R3 nofwd", {31'd0, ack_out}, 32'd0);
      @(negedge clk);
      chk("R3 irq low", {31'd0, irq}, 32'd0);
      chk("R3 id drive", {31'd0, bus_drive}, 32'd1);
      if (k == 0) chk("R8 id wins", bus_data, 32'd2);
      else chk("R3 id", bus_data, 32'd2);
      chk("R3 nofwd2", {31'd0, ack_out}, 32'd0);
      ack_in = 1'b0;
      dev_addr = 32'd0;
      @(negedge clk);
      chk("R3 one cycle", {31'd0, bus_drive}, 32'd0);
    end
    done = 1'b1;
    finish_up();
  end
endmodule